// File: doc/BRIEF.md
# Fixed-Length Triangle Code Decoder

This block expands a compressed mesh topology stream into triangles. Each 16-bit input word describes one triangle. The decoder turns it into three vertex indices for the primitive assembly stage that follows. It keeps a small mirror of the post-shading vertex cache: a first-in first-out list of the most recently introduced vertex indices. Most vertices are therefore named by a short slot address instead of a full index.

The top three bits of a word give its case. The body below them carries slot addresses, a signed reload offset, or both. A vertex used for the first time carries no bits at all. It takes the value of a running counter, which then advances. A vertex that was flushed and is needed again is rebuilt from a signed offset against the last reloaded index. The mirror does not resolve duplicate indices, and a vertex already present is never refreshed. Words enter and triangles leave through valid/ready handshakes. Each triangle carries a flag for a repeated index and a flag for a reserved case code.

Top module: `tri_decode`

## Requirements
- R1: After reset the output is not valid, the input is ready, the first-use counter and the reload base are zero, and every cache slot holds index 0.
- R2: The decoder accepts a word when inValid is high and inReady is high, where inReady = !outValid || outReady. The triangle of that word appears at the output on the next clock edge. While outValid is high and outReady is low, the output holds every field unchanged.
- R3: The case field is word bits [15:13]. The codes are: 0 = new,new,slotA; 1 = new,slotA,slotB; 2 = new,slotA,reload; 3 = slotA,slotB,slot0; 4 = slotA,slotB,slot1; 5 = reserved; 6 = slotA,slotB,reload; 7 = reload repeated three times.
- R4: A new vertex takes the current counter value. A second new vertex in the same word takes the value plus one. The counter then advances by the number of new vertices.
- R5: slotA is bits [12:9] and slotB is bits [8:5] (for the default 16-entry cache). Slot 0 holds the most recently inserted index. Every slot read in a word sees the cache as it was before that word.
- R6: Codes 3 and 4 take their third vertex implicitly from slot 0 and slot 1 respectively.
- R7: A reload vertex equals the reload base plus a two's-complement offset in the low body bits: 9 bits for code 2, 5 bits for code 6, 13 bits for code 7. The result becomes the new reload base.
- R8: Code 7 outputs the reloaded index in all three positions and inserts it into the cache once.
- R9: New and reloaded vertices are inserted in triangle position order, so the last one inserted ends in slot 0. Slot hits do not reorder the cache. The oldest entry drops off when a 17th entry arrives.
- R10: Code 5 produces one output triangle with the bad flag set, all indices zero and the degenerate flag clear. It leaves the counter, the reload base and the cache unchanged.
- R11: The degenerate flag is set exactly when at least two of the three output indices are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input word is present |
| inReady | output | 1 | Decoder can take a word this cycle |
| inWord | input | 16 | Triangle code word |
| outValid | output | 1 | Output triangle is present |
| outReady | input | 1 | Consumer takes the triangle this cycle |
| outIdx0 | output | 16 | First vertex index |
| outIdx1 | output | 16 | Second vertex index |
| outIdx2 | output | 16 | Third vertex index |
| outDegen | output | 1 | Two or more indices are equal |
| outBad | output | 1 | Word carried the reserved case code |

## Verification
Each accepted word produces its triangle one edge later. The bench drives a word at a falling edge and lets the next rising edge accept it. It reads the indices and flags at the falling edge after that. The cache, counter and reload base change at that same accepting edge. The next word, sent one cycle later, reads that updated state, which lets the bench observe ordering, eviction and reserved-code effects through the following triangle. For the stall case the bench holds outReady low for several cycles and samples the same triangle at each falling edge. It then releases outReady and expects the waiting word's triangle one edge after release.

// File: rtl/tricode_pkg.sv
package tricode_pkg;

  typedef enum logic [2:0] {
    CASE_NNS  = 3'd0,
    CASE_NSS  = 3'd1,
    CASE_NSR  = 3'd2,
    CASE_SS0  = 3'd3,
    CASE_SS1  = 3'd4,
    CASE_RSVD = 3'd5,
    CASE_SSR  = 3'd6,
    CASE_DDR  = 3'd7
  } triCase_e;

  typedef enum logic [2:0] {
    SRC_NEW,
    SRC_SLOTA,
    SRC_SLOTB,
    SRC_FIX0,
    SRC_FIX1,
    SRC_RELOAD
  } vtxSrc_e;

  typedef enum logic [1:0] {
    OFF_NONE,
    OFF_ONE,
    OFF_TWO,
    OFF_FULL
  } offSel_e;

  // strobes from control to datapath, one set per accepted word
  typedef struct packed {
    logic     take;
    logic     bad;
    vtxSrc_e  src0;
    vtxSrc_e  src1;
    vtxSrc_e  src2;
    logic [2:0] pushMask;
    logic [2:0] newMask;
    offSel_e  offSel;
  } triStb_t;

endpackage

// File: rtl/tri_ctrl.sv
module tri_ctrl
  import tricode_pkg::*;
(
  input  logic       inValid,
  input  logic [2:0] inCase,
  input  logic       outValid,
  input  logic       outReady,
  output logic       inReady,
  output triStb_t    stb
);

  logic take;

  assign inReady = !outValid || outReady;
  assign take    = inValid && inReady;

  always_comb begin
    stb          = '0;
    stb.take     = take;
    stb.src0     = SRC_NEW;
    stb.src1     = SRC_NEW;
    stb.src2     = SRC_NEW;
    stb.offSel   = OFF_NONE;
    unique case (triCase_e'(inCase))
      CASE_NNS: begin
        stb.src2     = SRC_SLOTA;
        stb.newMask  = 3'b011;
        stb.pushMask = 3'b011;
      end
      CASE_NSS: begin
        stb.src1     = SRC_SLOTA;
        stb.src2     = SRC_SLOTB;
        stb.newMask  = 3'b001;
        stb.pushMask = 3'b001;
      end
      CASE_NSR: begin
        stb.src1     = SRC_SLOTA;
        stb.src2     = SRC_RELOAD;
        stb.newMask  = 3'b001;
        stb.pushMask = 3'b101;
        stb.offSel   = OFF_ONE;
      end
      CASE_SS0: begin
        stb.src0 = SRC_SLOTA;
        stb.src1 = SRC_SLOTB;
        stb.src2 = SRC_FIX0;
      end
      CASE_SS1: begin
        stb.src0 = SRC_SLOTA;
        stb.src1 = SRC_SLOTB;
        stb.src2 = SRC_FIX1;
      end
      CASE_SSR: begin
        stb.src0     = SRC_SLOTA;
        stb.src1     = SRC_SLOTB;
        stb.src2     = SRC_RELOAD;
        stb.pushMask = 3'b100;
        stb.offSel   = OFF_TWO;
      end
      CASE_DDR: begin
        stb.src0     = SRC_RELOAD;
        stb.src1     = SRC_RELOAD;
        stb.src2     = SRC_RELOAD;
        stb.pushMask = 3'b001;
        stb.offSel   = OFF_FULL;
      end
      default: begin
        stb.bad = 1'b1;
      end
    endcase
    if (!take) begin
      stb.pushMask = 3'b000;
      stb.newMask  = 3'b000;
      stb.offSel   = OFF_NONE;
    end
  end

endmodule

// File: rtl/tri_data.sv
module tri_data
  import tricode_pkg::*;
#(
  parameter int BODY_W = 13,
  parameter int IDX_W  = 16,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  triStb_t           stb,
  input  logic [BODY_W-1:0] body,
  input  logic              outReady,
  output logic              outValid,
  output logic [IDX_W-1:0]  outIdx0,
  output logic [IDX_W-1:0]  outIdx1,
  output logic [IDX_W-1:0]  outIdx2,
  output logic              outDegen,
  output logic              outBad
);

  localparam int SLOT_W = $clog2(DEPTH);
  localparam int OFF1_W = BODY_W - SLOT_W;
  localparam int OFF2_W = BODY_W - 2 * SLOT_W;

  logic [IDX_W-1:0] fifo     [DEPTH];
  logic [IDX_W-1:0] fifoNext [DEPTH];
  logic [IDX_W-1:0] newCnt;
  logic [IDX_W-1:0] reloadBase;

  logic [SLOT_W-1:0] slotA, slotB;
  logic [IDX_W-1:0]  offExt, reloadVal;
  logic [IDX_W-1:0]  vtx [3];
  vtxSrc_e           srcArr [3];
  logic [1:0]        newBefore [3];
  logic [1:0]        newTotal;
  logic              degen;

  assign slotA     = body[BODY_W-1 -: SLOT_W];
  assign slotB     = body[BODY_W-1-SLOT_W -: SLOT_W];
  assign srcArr[0] = stb.src0;
  assign srcArr[1] = stb.src1;
  assign srcArr[2] = stb.src2;

  always_comb begin
    unique case (stb.offSel)
      OFF_ONE:  offExt = IDX_W'($signed(body[OFF1_W-1:0]));
      OFF_TWO:  offExt = IDX_W'($signed(body[OFF2_W-1:0]));
      OFF_FULL: offExt = IDX_W'($signed(body));
      default:  offExt = '0;
    endcase
    reloadVal = reloadBase + offExt;
  end

  assign newBefore[0] = 2'd0;
  assign newBefore[1] = {1'b0, stb.newMask[0]};
  assign newBefore[2] = {1'b0, stb.newMask[0]} + {1'b0, stb.newMask[1]};
  assign newTotal     = newBefore[2] + {1'b0, stb.newMask[2]};

  generate
    for (genvar p = 0; p < 3; p++) begin : g_pos
      always_comb begin
        unique case (srcArr[p])
          SRC_NEW:    vtx[p] = newCnt + IDX_W'(newBefore[p]);
          SRC_SLOTA:  vtx[p] = fifo[slotA];
          SRC_SLOTB:  vtx[p] = fifo[slotB];
          SRC_FIX0:   vtx[p] = fifo[0];
          SRC_FIX1:   vtx[p] = fifo[1];
          SRC_RELOAD: vtx[p] = reloadVal;
          default:    vtx[p] = '0;
        endcase
      end
    end
  endgenerate

  assign degen = (vtx[0] == vtx[1]) || (vtx[1] == vtx[2]) || (vtx[0] == vtx[2]);

  // insert in triangle position order; the last insert ends in slot 0
  always_comb begin
    fifoNext = fifo;
    for (int p = 0; p < 3; p++) begin
      if (stb.pushMask[p]) begin
        for (int j = DEPTH - 1; j > 0; j--) fifoNext[j] = fifoNext[j-1];
        fifoNext[0] = vtx[p];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int j = 0; j < DEPTH; j++) fifo[j] <= '0;
      newCnt     <= '0;
      reloadBase <= '0;
    end else begin
      fifo   <= fifoNext;
      newCnt <= newCnt + IDX_W'(newTotal);
      if (stb.offSel != OFF_NONE) reloadBase <= reloadVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outIdx0  <= '0;
      outIdx1  <= '0;
      outIdx2  <= '0;
      outDegen <= 1'b0;
      outBad   <= 1'b0;
    end else if (stb.take) begin
      outValid <= 1'b1;
      outBad   <= stb.bad;
      outIdx0  <= stb.bad ? '0 : vtx[0];
      outIdx1  <= stb.bad ? '0 : vtx[1];
      outIdx2  <= stb.bad ? '0 : vtx[2];
      outDegen <= stb.bad ? 1'b0 : degen;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outIdx0) && $stable(outIdx1)
                              && $stable(outIdx2) && $stable(outDegen) && $stable(outBad));

  assert_pair_R4: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.take) && $past(stb.newMask) == 3'b011 |-> outIdx1 == outIdx0 + 1'b1);

  assert_triple_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.take) && $past(stb.src0) == SRC_RELOAD && $past(stb.src1) == SRC_RELOAD
      |-> outIdx0 == outIdx1 && outIdx1 == outIdx2 && outDegen);

  assert_bad_R10: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outBad |-> outIdx0 == '0 && outIdx1 == '0 && outIdx2 == '0 && !outDegen);

endmodule

// File: rtl/tri_decode.sv
module tri_decode
  import tricode_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int IDX_W  = 16,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [WORD_W-1:0] inWord,
  output logic              outValid,
  input  logic              outReady,
  output logic [IDX_W-1:0]  outIdx0,
  output logic [IDX_W-1:0]  outIdx1,
  output logic [IDX_W-1:0]  outIdx2,
  output logic              outDegen,
  output logic              outBad
);

  localparam int CASE_W = 3;
  localparam int BODY_W = WORD_W - CASE_W;

  triStb_t stb;

  tri_ctrl u_ctrl (
    .inValid  (inValid),
    .inCase   (inWord[WORD_W-1 -: CASE_W]),
    .outValid (outValid),
    .outReady (outReady),
    .inReady  (inReady),
    .stb      (stb)
  );

  tri_data #(
    .BODY_W (BODY_W),
    .IDX_W  (IDX_W),
    .DEPTH  (DEPTH)
  ) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .body     (inWord[BODY_W-1:0]),
    .outReady (outReady),
    .outValid (outValid),
    .outIdx0  (outIdx0),
    .outIdx1  (outIdx1),
    .outIdx2  (outIdx2),
    .outDegen (outDegen),
    .outBad   (outBad)
  );

endmodule

// File: tb/sim_tri_decode.sv
module sim_tri_decode;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [15:0] inWord = '0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [15:0] outIdx0, outIdx1, outIdx2;
  logic        outDegen, outBad;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  tri_decode u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inWord(inWord),
    .outValid(outValid), .outReady(outReady), .outIdx0(outIdx0), .outIdx1(outIdx1),
    .outIdx2(outIdx2), .outDegen(outDegen), .outBad(outBad)
  );

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one word per call; triangle is sampled at the falling edge after acceptance
  task automatic sendCheck(input logic [15:0] w, input logic [15:0] e0, input logic [15:0] e1,
                           input logic [15:0] e2, input logic eDeg, input logic eBad, input string tag);
    @(negedge clk);
    inWord = w; inValid = 1'b1; outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    chk(outValid && {outIdx0, outIdx1, outIdx2} == {e0, e1, e2}, tag,
        {15'd0, outValid, outIdx0, outIdx1, outIdx2}, {16'd1, e0, e1, e2});
    chk(outDegen == eDeg && outBad == eBad, {tag, " flags R11"},
        {62'd0, outDegen, outBad}, {62'd0, eDeg, eBad});
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(!outValid && inReady, "R1 reset state", {62'd0, outValid, inReady}, 64'd1);
  endtask

  task automatic testBasic();
    sendCheck({3'd0, 4'd0, 9'd0}, 16'd0, 16'd1, 16'd0, 1'b1, 1'b0, "R1 R4 first new pair, zeroed slot");
    sendCheck({3'd1, 4'd1, 4'd0, 5'd0}, 16'd2, 16'd0, 16'd1, 1'b0, 1'b0, "R5 new plus two slots");
    sendCheck({3'd3, 4'd2, 4'd1, 5'd0}, 16'd0, 16'd1, 16'd2, 1'b0, 1'b0, "R6 implicit slot0");
    sendCheck({3'd4, 4'd0, 4'd2, 5'd0}, 16'd2, 16'd0, 16'd1, 1'b0, 1'b0, "R6 implicit slot1");
  endtask

  task automatic testReload();
    sendCheck({3'd7, 13'd5}, 16'd5, 16'd5, 16'd5, 1'b1, 1'b0, "R8 degenerate reload");
    sendCheck({3'd6, 4'd1, 4'd3, 5'b11111}, 16'd2, 16'd0, 16'd4, 1'b0, 1'b0, "R7 negative short offset");
    sendCheck({3'd2, 4'd1, 9'd10}, 16'd3, 16'd5, 16'd14, 1'b0, 1'b0, "R7 R4 new plus reload");
    sendCheck({3'd3, 4'd2, 4'd1, 5'd0}, 16'd4, 16'd3, 16'd14, 1'b0, 1'b0, "R9 insert order");
  endtask

  task automatic testReserved();
    sendCheck({3'd5, 13'h1ABC}, 16'd0, 16'd0, 16'd0, 1'b0, 1'b1, "R10 reserved code");
    sendCheck({3'd4, 4'd0, 4'd0, 5'd0}, 16'd14, 16'd14, 16'd3, 1'b1, 1'b0, "R10 state untouched");
  endtask

  task automatic testEvict();
    for (int j = 0; j < 8; j++) begin
      sendCheck({3'd0, 4'd0, 9'd0}, 16'(4 + 2 * j), 16'(5 + 2 * j),
                (j == 0) ? 16'd14 : 16'(3 + 2 * j), 1'b0, 1'b0, "R4 R3 fill stream");
    end
    sendCheck({3'd3, 4'd15, 4'd14, 5'd0}, 16'd4, 16'd5, 16'd19, 1'b0, 1'b0, "R9 oldest evicted");
    sendCheck({3'd7, 13'h1FF2}, 16'd0, 16'd0, 16'd0, 1'b1, 1'b0, "R7 full width negative");
    sendCheck({3'd7, 13'h0FFF}, 16'd4095, 16'd4095, 16'd4095, 1'b1, 1'b0, "R7 full width positive");
  endtask

  task automatic testStall();
    @(negedge clk);
    outReady = 1'b0; inWord = {3'd1, 4'd0, 4'd1, 5'd0}; inValid = 1'b1;
    @(negedge clk);
    inWord = {3'd0, 4'd1, 9'd0};
    chk(outValid && !inReady, "R2 stall backpressure", {62'd0, outValid, inReady}, 64'd2);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(outValid && {outIdx0, outIdx1, outIdx2} == {16'd20, 16'd4095, 16'd0}, "R2 hold while stalled",
          {16'd0, outIdx0, outIdx1, outIdx2}, {16'd0, 16'd20, 16'd4095, 16'd0});
    end
    outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    chk(outValid && {outIdx0, outIdx1, outIdx2} == {16'd21, 16'd22, 16'd4095}, "R2 release takes next",
        {16'd0, outIdx0, outIdx1, outIdx2}, {16'd0, 16'd21, 16'd22, 16'd4095});
    @(negedge clk);
    chk(!outValid, "R2 drain", {63'd0, outValid}, 64'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testBasic();
    testReload();
    testReserved();
    testEvict();
    testStall();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule